// File: doc/BRIEF.md
# Timer clock source selector

This block decides, on every cycle of the system clock, whether an attached timer counter may advance. It drives a one-cycle count-enable strobe whose source is picked by a 3-bit select code. The strobe can be held off, raised on every clock, raised at one of four power-of-two rates taken from a shared free-running prescaler, or raised once per falling or rising edge of an external pin.

The external pin is brought into the clock domain through a two-flop synchroniser before its edges are found. The pin is sampled no matter how its pad direction is set, so software that drives the pin as an output can still make the timer count. A prescaler clear input restarts the shared divider. This lets software line up the first divided strobe with a known moment.

The strobe is registered. A change of select code therefore shows one clock later, and the newly selected source alone decides it.

Top module: `tmr_clk_sel`

## Requirements
- R1: With select code 3'b000 the block is stopped, and `cnt_en` stays low on every cycle after the code is sampled.
- R2: With select code 3'b001, `cnt_en` is high on every cycle after the code is sampled (no division).
- R3: Select codes 3'b010, 3'b011, 3'b100 and 3'b101 give one single-cycle `cnt_en` pulse per 8, 64, 256 and 1024 clocks. A pulse follows the clock edge at which a 10-bit free-running prescaler that counts from 0 holds N-1 in its low log2(N) bits.
- R4: With select code 3'b110, each falling edge of `ext_pin` gives exactly one `cnt_en` pulse. The pulse is high in the cycle after the third rising clock edge that follows the pin change.
- R5: With select code 3'b111, each rising edge of `ext_pin` gives exactly one `cnt_en` pulse, with the same three-edge latency as R4.
- R6: `psc_clr` sampled high sets the prescaler to zero, and no divided pulse follows that edge. The next divided pulse comes a full ratio N clocks after the clear edge.
- R7: A new select code takes effect at the first clock edge that samples it. The strobe in the following cycle comes only from the new source, with the prescaler phase unchanged by the switch.
- R8: While `rst` is sampled high, `cnt_en` is low, the prescaler and synchroniser clear to zero, and counting resumes from prescaler value 0 when reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 3 | Clock source select code |
| ext_pin | input | 1 | External count pin, asynchronous to clk |
| psc_clr | input | 1 | Synchronous prescaler clear |
| cnt_en | output | 1 | Registered count-enable strobe |

## Verification
The checker checks the following on every cycle:
- the stop and undivided codes;
- that a divided pulse lasts one cycle and is suppressed right after a prescaler clear;
- that a strobe in pin mode equals the rising or falling pattern seen on the pin three and four cycles earlier;
- that the strobe is quiet after reset.

The exact spacing of divided pulses (up to 1024 cycles), the phase kept across select changes, and the restart after a clear or reset are shown only by the bench. Its arithmetic model runs alongside the design through every code, random pin activity and irregular switching.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    localparam int PSC_W      = 10;
    localparam int NUM_TAPS   = 4;
    localparam int SYNC_DEPTH = 2;
    localparam int SEL_W      = 3;

    typedef enum logic [SEL_W-1:0] {
        SRC_OFF      = 3'd0,
        SRC_SYS      = 3'd1,
        SRC_D8       = 3'd2,
        SRC_D64      = 3'd3,
        SRC_D256     = 3'd4,
        SRC_D1024    = 3'd5,
        SRC_PIN_FALL = 3'd6,
        SRC_PIN_RISE = 3'd7
    } clk_src_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } pin_edges_t;

    // log2 of the division ratio for each prescaler tap
    function automatic int tap_width(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

    function automatic logic src_is_div(input clk_src_e s);
        return (s == SRC_D8) || (s == SRC_D64) || (s == SRC_D256) || (s == SRC_D1024);
    endfunction

endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler
    import tcs_pkg::*;
#(
    parameter int W     = PSC_W,
    parameter int NTAPS = NUM_TAPS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    output logic [NTAPS-1:0] tap_hit
);

    logic [W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

    // A tap fires when the low bits for its ratio are all ones.
    // A clear in the same cycle suppresses it so the next pulse is a full period away.
    for (genvar i = 0; i < NTAPS; i++) begin : g_tap
        localparam int TW = tap_width(i);
        assign tap_hit[i] = (&count_q[TW-1:0]) & ~clr;
    end

endmodule

// File: rtl/tcs_pin_edge.sv
module tcs_pin_edge
    import tcs_pkg::*;
#(
    parameter int DEPTH = SYNC_DEPTH
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin,
    output pin_edges_t edges
);

    // DEPTH synchroniser flops plus one history flop
    logic [DEPTH:0] shreg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
        end else begin
            shreg_q <= {shreg_q[DEPTH-1:0], pin};
        end
    end

    assign edges.rise =  shreg_q[DEPTH-1] & ~shreg_q[DEPTH];
    assign edges.fall = ~shreg_q[DEPTH-1] &  shreg_q[DEPTH];

endmodule

// File: rtl/tcs_src_mux.sv
module tcs_src_mux
    import tcs_pkg::*;
#(
    parameter int NTAPS = NUM_TAPS
) (
    input  logic             clk,
    input  logic             rst,
    input  clk_src_e         src,
    input  logic [NTAPS-1:0] tap_hit,
    input  pin_edges_t       edges,
    output logic             strobe
);

    logic strobe_d;

    always_comb begin
        case (src)
            SRC_OFF:      strobe_d = 1'b0;
            SRC_SYS:      strobe_d = 1'b1;
            SRC_D8:       strobe_d = tap_hit[0];
            SRC_D64:      strobe_d = tap_hit[1];
            SRC_D256:     strobe_d = tap_hit[2];
            SRC_D1024:    strobe_d = tap_hit[NTAPS-1];
            SRC_PIN_FALL: strobe_d = edges.fall;
            SRC_PIN_RISE: strobe_d = edges.rise;
            default:      strobe_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe <= 1'b0;
        end else begin
            strobe <= strobe_d;
        end
    end

endmodule

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel
    import tcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic             ext_pin,
    input  logic             psc_clr,
    output logic             cnt_en
);

    logic [NUM_TAPS-1:0] tap_hit;
    pin_edges_t          edges;
    clk_src_e            src;

    assign src = clk_src_e'(sel);

    tcs_prescaler #(.W(PSC_W), .NTAPS(NUM_TAPS)) u_psc (
        .clk     (clk),
        .rst     (rst),
        .clr     (psc_clr),
        .tap_hit (tap_hit)
    );

    tcs_pin_edge #(.DEPTH(SYNC_DEPTH)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .pin   (ext_pin),
        .edges (edges)
    );

    tcs_src_mux #(.NTAPS(NUM_TAPS)) u_mux (
        .clk     (clk),
        .rst     (rst),
        .src     (src),
        .tap_hit (tap_hit),
        .edges   (edges),
        .strobe  (cnt_en)
    );

endmodule

// File: rtl/tcs_checker.sv
module tcs_checker
    import tcs_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [SEL_W-1:0] sel,
    input logic             ext_pin,
    input logic             psc_clr,
    input logic             cnt_en
);

    logic [2:0] warm_q;
    logic       rst_q;
    logic       seen_q;

    always_ff @(posedge clk) begin
        rst_q  <= rst;
        seen_q <= 1'b1;
        if (rst) begin
            warm_q <= '0;
        end else if (warm_q != 3'd7) begin
            warm_q <= warm_q + 3'd1;
        end
    end

    function automatic logic is_div(input logic [SEL_W-1:0] s);
        return (s >= 3'd2) && (s <= 3'd5);
    endfunction

    p_stop_r1: assert property (@(posedge clk) disable iff (rst)
        (sel == 3'b000) |=> !cnt_en);

    p_every_clk_r2: assert property (@(posedge clk) disable iff (rst)
        (sel == 3'b001) |=> cnt_en);

    p_div_single_r3: assert property (@(posedge clk) disable iff (rst)
        (is_div(sel) && is_div($past(sel)) && cnt_en && warm_q != 3'd0) |=> !cnt_en);

    p_fall_r4: assert property (@(posedge clk) disable iff (rst)
        (warm_q >= 3'd4 && sel == 3'b110) |=>
            (cnt_en == (!$past(ext_pin, 3) && $past(ext_pin, 4))));

    p_rise_r5: assert property (@(posedge clk) disable iff (rst)
        (warm_q >= 3'd4 && sel == 3'b111) |=>
            (cnt_en == ($past(ext_pin, 3) && !$past(ext_pin, 4))));

    p_clr_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (psc_clr && is_div(sel)) |=> !cnt_en);

    // R8: the cycle after a sampled reset shows no strobe
    always @(posedge clk) begin
        if (seen_q && rst_q) begin
            p_reset_quiet_r8: assert (!cnt_en);
        end
    end

endmodule

bind tmr_clk_sel tcs_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel),
    .ext_pin (ext_pin),
    .psc_clr (psc_clr),
    .cnt_en  (cnt_en)
);

// File: tb/tmr_clk_sel_bench.sv
module tmr_clk_sel_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] sel = 3'd0;
    logic       ext_pin = 1'b0;
    logic       psc_clr = 1'b0;
    logic       cnt_en;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    // model state
    int         since = 0;
    logic [2:0] hist  = 3'b000;
    logic [2:0] prev_sel = 3'd0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    tmr_clk_sel u_tmr_clk_sel (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .ext_pin (ext_pin),
        .psc_clr (psc_clr),
        .cnt_en  (cnt_en)
    );

    function automatic int ratio(input logic [2:0] s);
        case (s)
            3'd2:    return 8;
            3'd3:    return 64;
            3'd4:    return 256;
            default: return 1024;
        endcase
    endfunction

    function automatic string tag_for(input logic r, input logic [2:0] s,
                                      input logic c, input logic chg);
        if (r) return "R8";
        if (c && s >= 3'd2 && s <= 3'd5) return "R6";
        if (chg) return "R7";
        case (s)
            3'd0:    return "R1";
            3'd1:    return "R2";
            3'd6:    return "R4";
            3'd7:    return "R5";
            default: return "R3";
        endcase
    endfunction

    task automatic tick(input logic r, input logic [2:0] s, input logic p, input logic c);
        logic exp;
        string tg;
        rst = r; sel = s; ext_pin = p; psc_clr = c;
        @(posedge clk);
        @(negedge clk);
        cyc++;
        if (r) begin
            exp = 1'b0;
        end else begin
            case (s)
                3'd0: exp = 1'b0;
                3'd1: exp = 1'b1;
                3'd6: exp = ~hist[1] &  hist[2];
                3'd7: exp =  hist[1] & ~hist[2];
                default: exp = ((since % ratio(s)) == ratio(s) - 1) && !c;
            endcase
        end
        if (r) begin
            hist  = 3'b000;
            since = 0;
        end else begin
            hist  = {hist[1:0], p};
            since = c ? 0 : since + 1;
        end
        tg = tag_for(r, s, c, !r && (s != prev_sel));
        prev_sel = s;
        checks++;
        if (cnt_en !== exp) begin
            errors++;
            $display("FAIL %s: cycle %0d sel=%0d cnt_en=%0b expected %0b",
                     tg, cyc, s, cnt_en, exp);
        end
    endtask

    function automatic logic next_pin();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: cycle %0d run did not end, expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R8: reset state
        for (int i = 0; i < 4; i++) tick(1'b1, 3'd2, 1'b1, 1'b0);

        // R1..R6: sweep every select code with random pin activity and a mid-run clear
        for (int s = 0; s < 8; s++) begin
            for (int i = 0; i < 1100; i++) begin
                tick(1'b0, 3'(s), next_pin(), (i == 300) || (i == 305));
            end
        end

        // R4/R5: slow pin, wide pulses
        for (int i = 0; i < 200; i++) tick(1'b0, 3'd7, ((i / 9) % 2) == 1, 1'b0);
        for (int i = 0; i < 200; i++) tick(1'b0, 3'd6, ((i / 5) % 2) == 1, 1'b0);

        // R7: irregular switching among all sources, prescaler phase kept
        begin
            int idx = 0;
            int left = 3;
            for (int i = 0; i < 2000; i++) begin
                if (left == 0) begin
                    idx  = (idx * 5 + 3) % 8;
                    left = 3 + (i % 7);
                end
                left--;
                tick(1'b0, 3'(idx), next_pin(), (i % 411) == 17);
            end
        end

        // R8: reset mid-run then restart in divide-by-8 from zero
        for (int i = 0; i < 3; i++) tick(1'b1, 3'd2, next_pin(), 1'b0);
        for (int i = 0; i < 40; i++) tick(1'b0, 3'd2, next_pin(), 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule